// File: doc/BRIEF.md
# Serial-to-Word Deserializer with Comma Alignment and Shaped Byte Clock

This block sits on the receive side of a 10-bit line code link, clocked by the recovered bit-rate clock. One of two serial data lines is picked by a select input, and each bit is shifted into a 10-bit register. A divide-by-10 counter marks code-group boundaries. On every wrap of that counter the register contents are copied into an output word register, and a one-cycle strobe goes with the copy.

When framing is enabled, an alignment detector looks at the oldest seven bits of the shift register for either polarity of the comma sequence. A hit that does not already sit on a boundary copies the group at once, raises a realign flag with that copy, and restarts the counter, so later groups are cut at the new boundary. A byte-rate clock is taken from the same counter. A restart of the counter can lengthen this clock's high phase, low phase or period, but it never makes any of them shorter than normal.

Top module: `rxd_deser_framer`

## Requirements
- R1: When `sel_a` is 1 the bit on `ser_a` is shifted in; when it is 0 the bit on `ser_b` is shifted in.
- R2: Every 10 bit cycles `dec_valid` pulses for one cycle and `dec_word` holds the last 10 bits received, with the earliest received bit in bit 9 and the latest in bit 0.
- R3: With `frame_en` at 1, when `dec_word`-order bits 9..3 of the shift register equal 0011111 or 1100000 and that cycle is not a boundary cycle, the group is loaded at once, and the next load follows exactly 10 cycles later.
- R4: With `frame_en` at 0, a comma anywhere in the stream neither loads a word nor moves the load schedule, and `dec_realign` stays 0.
- R5: `dec_realign` is 1 only together with `dec_valid`, and only for a load that moved the boundary; a comma that already lies on a boundary loads with `dec_realign` at 0.
- R6: Without reframing, `byte_clk` is high for 5 cycles and low for 5 cycles, and every rise comes in the cycle right after a `dec_valid` strobe.
- R7: No high or low phase of `byte_clk` is ever shorter than 5 cycles, including around a reframe.
- R8: After a single isolated reframe decided while the boundary count is c (0..8 cycles past the last boundary), the longest `byte_clk` phase is c+6 cycles, and no period exceeds 19 cycles.
- R9: Synchronous reset clears the word, both flags and `byte_clk`; the first `dec_valid` appears 10 cycles after the first cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 1 | Line select: 1 picks `ser_a`, 0 picks `ser_b` |
| ser_a | input | 1 | Serial data line A |
| ser_b | input | 1 | Serial data line B |
| frame_en | input | 1 | Allows a comma to realign the boundary |
| dec_word | output | 10 | Last complete code group, first bit in the MSB |
| dec_valid | output | 1 | One-cycle strobe on each word load |
| dec_realign | output | 1 | Marks a load caused by a boundary move |
| byte_clk | output | 1 | Byte-rate clock derived from the boundary counter |

## Verification
A comma can complete in the very cycle the counter wraps. The bench provokes this by placing a comma so that it ends on the boundary. It then expects a single ordinary load with no realign flag, not a reframe. A reframe can also fall on a cycle where the byte clock is due to rise or fall. The bench sweeps the comma position over every count from 0 to 8 and checks that the longest phase equals c+6, that no phase falls below 5 cycles, and that the period stays within 19.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    // default code group width and comma window
    localparam int unsigned GRP_W_DEF = 10;
    localparam int unsigned MARK_W    = 7;

    localparam logic [MARK_W-1:0] MARK_POS = 7'b0011111;
    localparam logic [MARK_W-1:0] MARK_NEG = 7'b1100000;

    // per-cycle transfer decision of the framer
    typedef struct packed {
        logic load;
        logic realign;
    } xfer_t;

    // level of the shaped byte clock
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } bclk_phase_e;

    function automatic logic is_mark(input logic [MARK_W-1:0] win);
        return (win == MARK_POS) || (win == MARK_NEG);
    endfunction

endpackage

// File: rtl/rxd_shifter.sv
module rxd_shifter #(
    parameter int unsigned GRP_W = rxd_pkg::GRP_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_a,
    input  logic             ser_a,
    input  logic             ser_b,
    output logic [GRP_W-1:0] shreg
);

    logic picked;

    always_comb begin
        picked = sel_a ? ser_a : ser_b;
    end

    // oldest bit drifts toward the MSB
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[GRP_W-2:0], picked};
        end
    end

endmodule

// File: rtl/rxd_framer.sv
module rxd_framer #(
    parameter int unsigned GRP_W = rxd_pkg::GRP_W_DEF,
    localparam int unsigned CW   = $clog2(GRP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_en,
    input  logic [GRP_W-1:0] shreg,
    output logic [CW-1:0]    cnt,
    output rxd_pkg::xfer_t   xfer
);

    localparam logic [CW-1:0] LAST = CW'(GRP_W - 1);

    logic wrap;
    logic hit;

    always_comb begin
        wrap         = (cnt == LAST);
        hit          = rxd_pkg::is_mark(shreg[GRP_W-1 -: rxd_pkg::MARK_W]);
        xfer.realign = frame_en && hit && !wrap;
        xfer.load    = wrap || xfer.realign;
    end

    // boundary counter: restarts on every load, wrap or realign
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (xfer.load) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/rxd_clk_shaper.sv
module rxd_clk_shaper #(
    parameter int unsigned GRP_W = rxd_pkg::GRP_W_DEF,
    localparam int unsigned CW   = $clog2(GRP_W),
    localparam int unsigned HALF = GRP_W / 2,
    localparam int unsigned RMAX = 2 * GRP_W,
    localparam int unsigned RW   = $clog2(RMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    output logic          byte_clk
);

    rxd_pkg::bclk_phase_e ph;
    logic [RW-1:0]        run;
    logic                 long_enough;
    logic                 go_hi;
    logic                 go_lo;

    always_comb begin
        long_enough = (run >= RW'(HALF));
        go_hi = (ph == rxd_pkg::PH_LO) && (cnt == '0) && long_enough;
        go_lo = (ph == rxd_pkg::PH_HI) && (cnt == CW'(HALF)) && long_enough;
    end

    // edges only at fixed counter points, and only after a full half
    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= rxd_pkg::PH_LO;
            run <= RW'(HALF);
        end else if (go_hi || go_lo) begin
            ph  <= go_hi ? rxd_pkg::PH_HI : rxd_pkg::PH_LO;
            run <= RW'(1);
        end else if (run != RW'(RMAX)) begin
            run <= run + RW'(1);
        end
    end

    always_comb begin
        byte_clk = (ph == rxd_pkg::PH_HI);
    end

endmodule

// File: rtl/rxd_deser_framer.sv
module rxd_deser_framer #(
    parameter int unsigned GRP_W = rxd_pkg::GRP_W_DEF,
    localparam int unsigned CW   = $clog2(GRP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_a,
    input  logic             ser_a,
    input  logic             ser_b,
    input  logic             frame_en,
    output logic [GRP_W-1:0] dec_word,
    output logic             dec_valid,
    output logic             dec_realign,
    output logic             byte_clk
);

    logic [GRP_W-1:0] shreg;
    logic [CW-1:0]    cnt;
    rxd_pkg::xfer_t   xfer;

    rxd_shifter #(.GRP_W(GRP_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .sel_a (sel_a),
        .ser_a (ser_a),
        .ser_b (ser_b),
        .shreg (shreg)
    );

    rxd_framer #(.GRP_W(GRP_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .frame_en (frame_en),
        .shreg    (shreg),
        .cnt      (cnt),
        .xfer     (xfer)
    );

    rxd_clk_shaper #(.GRP_W(GRP_W)) u_bclk (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .byte_clk (byte_clk)
    );

    // decode register and its strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_word    <= '0;
            dec_valid   <= 1'b0;
            dec_realign <= 1'b0;
        end else begin
            if (xfer.load) begin
                dec_word <= shreg;
            end
            dec_valid   <= xfer.load;
            dec_realign <= xfer.realign;
        end
    end

endmodule

// File: rtl/rxd_deser_framer_chk.sv
module rxd_deser_framer_chk #(
    parameter int unsigned GRP_W = rxd_pkg::GRP_W_DEF,
    localparam int unsigned HALF = GRP_W / 2,
    localparam int unsigned CMAX = 4 * GRP_W,
    localparam int unsigned KW   = $clog2(CMAX + 1)
) (
    input logic clk,
    input logic rst,
    input logic frame_en,
    input logic dec_valid,
    input logic dec_realign,
    input logic byte_clk
);

    logic [KW-1:0] gap;
    logic [KW-1:0] ck_run;
    logic [KW-1:0] ck_per;
    logic          ck_lvl;
    logic          ck_seen;
    logic [1:0]    rl_n;
    logic          rise;

    always_comb begin
        rise = byte_clk && !ck_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= '0;
            ck_run  <= KW'(HALF);
            ck_per  <= '0;
            ck_lvl  <= 1'b0;
            ck_seen <= 1'b0;
            rl_n    <= '0;
        end else begin
            gap    <= dec_valid ? KW'(1) : ((gap == KW'(CMAX)) ? gap : gap + KW'(1));
            ck_run <= (byte_clk == ck_lvl) ? ((ck_run == KW'(CMAX)) ? ck_run : ck_run + KW'(1)) : KW'(1);
            ck_per <= rise ? KW'(1) : ((ck_per == KW'(CMAX)) ? ck_per : ck_per + KW'(1));
            ck_lvl <= byte_clk;
            if (rise) begin
                ck_seen <= 1'b1;
            end
            if (rise) begin
                rl_n <= {1'b0, dec_realign};
            end else if (dec_realign && rl_n != 2'd3) begin
                rl_n <= rl_n + 2'd1;
            end
        end
    end

    // R2: ordinary loads are spaced by one group
    assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_realign) |-> (gap == KW'(GRP_W)));

    // R4: a realign needs framing enabled in the deciding cycle
    assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
        dec_realign |-> $past(frame_en));

    // R5: realign flag only rides on a load
    assert_flag_with_load_R5: assert property (@(posedge clk) disable iff (rst)
        dec_realign |-> dec_valid);

    // R6: byte clock rises right after a load strobe
    assert_rise_after_load_R6: assert property (@(posedge clk) disable iff (rst)
        (rise && ck_seen) |-> $past(dec_valid));

    // R7: a phase that ends lasted at least half a group
    assert_min_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (byte_clk != ck_lvl) |-> (ck_run >= KW'(HALF)));

    // R8: period bound with at most one reframe in it
    assert_period_R8: assert property (@(posedge clk) disable iff (rst)
        (rise && ck_seen && rl_n <= 2'd1) |-> (ck_per <= KW'(2 * GRP_W - 1)));

endmodule

bind rxd_deser_framer rxd_deser_framer_chk #(.GRP_W(GRP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_en    (frame_en),
    .dec_valid   (dec_valid),
    .dec_realign (dec_realign),
    .byte_clk    (byte_clk)
);

// File: tb/sim_rxd_deser_framer.sv
module sim_rxd_deser_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_a = 1'b0;
    logic       ser_a = 1'b0;
    logic       ser_b = 1'b0;
    logic       frame_en = 1'b0;
    logic [9:0] dec_word;
    logic       dec_valid;
    logic       dec_realign;
    logic       byte_clk;

    always #4 clk = ~clk;

    rxd_deser_framer u0 (
        .clk         (clk),
        .rst         (rst),
        .sel_a       (sel_a),
        .ser_a       (ser_a),
        .ser_b       (ser_b),
        .frame_en    (frame_en),
        .dec_word    (dec_word),
        .dec_valid   (dec_valid),
        .dec_realign (dec_realign),
        .byte_clk    (byte_clk)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    logic [9:0] hist = '0;
    int         mcnt = 0;
    logic       exp_v = 1'b0;
    logic       exp_r = 1'b0;
    logic [9:0] exp_w = '0;
    bit         started = 1'b0;
    logic       fill = 1'b0;

    // byte clock observation
    logic prev_bc = 1'b0;
    logic prev_v  = 1'b0;
    int   run_b = 0;
    int   per_b = 0;
    int   rl_since = 0;
    int   quiet = 0;
    int   toggles = 0;
    int   rises = 0;
    int   max_ph = 0;
    int   rl_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step(input logic ba, input logic bb, input logic fe, input logic sa);
        logic hit;
        logic rl;
        logic ld;
        if (started) begin
            chk(dec_valid === exp_v, "R2 strobe", int'(dec_valid), int'(exp_v));
            chk(dec_realign === exp_r, "R3/R5 realign flag", int'(dec_realign), int'(exp_r));
            if (exp_v) chk(dec_word === exp_w, "R2 word", int'(dec_word), int'(exp_w));
            if (byte_clk !== prev_bc) begin
                if (toggles > 0) begin
                    chk(run_b >= 5, "R7 phase width", run_b, 5);
                    if (quiet > 30) chk(run_b == 5, "R6 steady phase", run_b, 5);
                    if (run_b > max_ph) max_ph = run_b;
                end
                if (byte_clk) begin
                    if (rises > 0) begin
                        chk(prev_v == 1'b1, "R6 rise after strobe", int'(prev_v), 1);
                        if (rl_since <= 1) chk(per_b <= 19, "R8 period", per_b, 19);
                    end
                    rises++;
                    per_b = 0;
                    rl_since = 0;
                end
                toggles++;
                run_b = 0;
            end
            run_b++;
            per_b++;
            if (dec_realign) begin
                rl_since++;
                rl_seen++;
                quiet = 0;
            end else begin
                quiet++;
            end
            prev_bc = byte_clk;
            prev_v  = dec_valid;
        end
        started = 1'b1;
        hit = (hist[9:3] == 7'b0011111) || (hist[9:3] == 7'b1100000);
        rl  = fe && hit && (mcnt != 9);
        ld  = (mcnt == 9) || rl;
        exp_v = ld;
        exp_r = rl;
        exp_w = hist;
        mcnt  = ld ? 0 : mcnt + 1;
        frame_en = fe;
        sel_a    = sa;
        ser_a    = ba;
        ser_b    = bb;
        hist = {hist[8:0], sa ? ba : bb};
        @(negedge clk);
    endtask

    task automatic filler(input int n, input logic fe);
        for (int i = 0; i < n; i++) begin
            fill = ~fill;
            step(fill, ~fill, fe, 1'b1);
        end
    endtask

    task automatic wait_count(input int target, input logic fe);
        while (mcnt != target) begin
            fill = ~fill;
            step(fill, ~fill, fe, 1'b1);
        end
    endtask

    task automatic send_group(input logic [9:0] g, input logic fe);
        for (int i = 9; i >= 0; i--) begin
            step(g[i], ~g[i], fe, 1'b1);
        end
        fill = g[0];
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(byte_clk === 1'b0, "R9 byte_clk reset", int'(byte_clk), 0);
        chk(dec_valid === 1'b0, "R9 valid reset", int'(dec_valid), 0);
        chk(dec_realign === 1'b0, "R9 flag reset", int'(dec_realign), 0);
        chk(dec_word === 10'd0, "R9 word reset", int'(dec_word), 0);
        rst = 1'b0;

        // R1, R2, R9: line B selected, line A carries the complement
        for (int i = 0; i < 60; i++) begin
            logic b;
            b = 1'($urandom);
            step(~b, b, 1'b0, 1'b0);
        end
        // R1: line A selected, line B carries the complement
        for (int i = 0; i < 60; i++) begin
            logic a;
            a = 1'($urandom);
            step(a, ~a, 1'b0, 1'b1);
        end

        // R6: steady byte clock with framing on
        filler(50, 1'b1);

        // R4: misaligned comma ignored while framing is off
        rl_seen = 0;
        wait_count(4, 1'b0);
        send_group(10'b0011111010, 1'b0);
        filler(30, 1'b0);
        chk(rl_seen == 0, "R4 no realign", rl_seen, 0);

        // R5: comma already on the boundary
        filler(20, 1'b1);
        rl_seen = 0;
        wait_count(9, 1'b1);
        send_group(10'b1100000101, 1'b1);
        filler(30, 1'b1);
        chk(rl_seen == 0, "R5 aligned comma", rl_seen, 0);

        // R3, R7, R8: sweep of the reframe position
        for (int c = 0; c <= 8; c++) begin
            filler(20, 1'b1);
            wait_count(c, 1'b1);
            max_ph  = 0;
            rl_seen = 0;
            if (c % 2 == 0) send_group(10'b0011111010, 1'b1);
            else            send_group(10'b1100000101, 1'b1);
            filler(40, 1'b1);
            chk(rl_seen == 1, "R3 one realign", rl_seen, 1);
            chk(max_ph == c + 6, "R8 longest phase", max_ph, c + 6);
        end

        filler(40, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule